// File: doc/BRIEF.md
# Indirect Word Access Port for Video Memory

This block gives a host processor a narrow window into a 16-bit, word-addressed video memory that the host cannot map directly. The host sees three registers: a location pointer, a data window and a step value. Each read or write through the window touches the word at the current location. After that access, the location moves forward by the programmed step.

The block drives a synchronous single-port RAM with address, write data and write enable. The RAM returns read data one cycle after the address is presented. The word at the current location is fetched ahead of time and kept in a one-word holding register. A read through the window can therefore be answered from that register, while the fetch for the next location starts in the same cycle. A stall input from the video side withholds the RAM port from the host. While it is high, the block keeps its ready output low.

Top module: `vram_port`

## Requirements
- R1: The host register offset (host_addr) selects the register: 0 is the location, 1 is the data window and 2 is the step. Reads of offsets 2 and 3 return 0, and writes to offset 3 change nothing.
- R2: A completed write to the window stores host_wdata at the current location. The location then becomes the old location plus the step.
- R3: A completed read of the window returns the word stored at the current location. The location then advances by the step.
- R4: A read of offset 0 returns the same word a window read would return. It does not advance the location, and the location value itself is never returned.
- R5: With a step of 0, window accesses leave the location where it was.
- R6: Location arithmetic wraps modulo 2^16.
- R7: While vid_stall is high, host_ready is low, no RAM write is issued and the location does not move. A held access completes once the stall clears.
- R8: After reset, the location and step are 0, host_ready is high with no stall and no RAM write is issued.
- R9: A data read issued in the cycle after a location write or a window read completes is ready after exactly one wait cycle. A window write is ready at once when not stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 2 | Register word offset |
| host_wr | input | 1 | Host write request (takes priority over read) |
| host_rd | input | 1 | Host read request |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, valid with host_ready |
| host_ready | output | 1 | Access completes at the clock edge where this is high |
| vid_stall | input | 1 | Video side holds the RAM port |
| mem_addr | output | 16 | RAM word address |
| mem_wdata | output | 16 | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_rdata | input | 16 | RAM read data, one cycle after the address |

## Verification
Errors in the location or step registers do not show up directly, because neither register can be read back. They show up one access later, as data landing at the wrong word or read back from the wrong word. The bench therefore writes pairs of words and then re-reads them from addresses it computes on its own. A stale or mistimed prefetch shows up on the very next data read as a wrong word or a wrong number of wait cycles. A stall leak shows up in the same cycle on host_ready or mem_we.

// File: rtl/vram_port.sv
module vram_port #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_ready,
  input  logic          vid_stall,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata
);
  localparam logic [1:0] OFS_LOC  = 2'd0;
  localparam logic [1:0] OFS_WIN  = 2'd1;
  localparam logic [1:0] OFS_STEP = 2'd2;

  logic [AW-1:0] loc, step, next_loc;
  logic [DW-1:0] pf_data;
  logic          pf_valid, fetch_q;

  wire rd_req      = host_rd && !host_wr;
  wire rd_data_req = rd_req && (host_addr == OFS_LOC || host_addr == OFS_WIN);

  assign host_ready = !vid_stall && (!rd_data_req || pf_valid);

  wire win_wr  = host_wr && host_addr == OFS_WIN  && host_ready;
  wire win_rd  = rd_req  && host_addr == OFS_WIN  && host_ready;
  wire loc_wr  = host_wr && host_addr == OFS_LOC  && host_ready;
  wire step_wr = host_wr && host_addr == OFS_STEP && host_ready;
  wire loc_change = win_wr || win_rd || loc_wr;

  assign next_loc = loc_wr ? AW'(host_wdata) : loc + step;

  wire fetch_now = !vid_stall && !win_wr && (loc_change || (!pf_valid && !fetch_q));

  assign mem_we     = win_wr;
  assign mem_wdata  = host_wdata;
  assign mem_addr   = (loc_change && !win_wr) ? next_loc : loc;
  assign host_rdata = rd_data_req ? pf_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loc      <= '0;
      step     <= '0;
      pf_data  <= '0;
      pf_valid <= 1'b0;
      fetch_q  <= 1'b0;
    end else begin
      if (loc_change) loc <= next_loc;
      if (step_wr) step <= AW'(host_wdata);
      fetch_q <= fetch_now;
      if (loc_change) pf_valid <= 1'b0;
      else if (fetch_q) begin
        pf_valid <= 1'b1;
        pf_data  <= mem_rdata;
      end
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vid_stall |-> (!host_ready && !mem_we));

  // R3
  rd_from_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_req && host_ready) |-> pf_valid);

  // R9
  fetch_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_q && !loc_change) |=> pf_valid);

  // R2
  wr_invalidate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_wr |=> (!pf_valid && !fetch_q));

  // R5
  zero_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_wr || win_rd) && step == '0) |=> $stable(loc));

  // R7
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vid_stall |=> $stable(loc) && $stable(step));
endmodule

// File: tb/sim_vram_port.sv
`timescale 1ns/1ps
module sim_vram_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  host_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        host_ready;
  logic        vid_stall = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vram_port u0 (.clk, .rst_n, .host_addr, .host_wr, .host_rd, .host_wdata,
    .host_rdata, .host_ready, .vid_stall, .mem_addr, .mem_wdata, .mem_we, .mem_rdata);

  logic [15:0] ram [256];
  initial for (int i = 0; i < 256; i++) ram[i] = '0;
  always_ff @(posedge clk) begin
    if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= ram[mem_addr[7:0]];
  end

  localparam logic [47:0] VEC [0:5] = '{
    {16'h0010, 16'h0001, 16'h1234},
    {16'h7000, 16'h0020, 16'hA5A5},
    {16'hFFFF, 16'h0002, 16'h0F0F},
    {16'h0042, 16'h0000, 16'h5555},
    {16'h8000, 16'h8001, 16'h3C3C},
    {16'h00FE, 16'hFFFF, 16'h7E81}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] a, input logic w, input logic [15:0] d,
                    output logic [15:0] q, output int waits);
    @(negedge clk);
    host_addr = a; host_wr = w; host_rd = !w; host_wdata = d; waits = 0;
    #1;
    while (!host_ready) begin
      @(negedge clk); #1; waits++;
    end
    q = host_rdata;
    @(posedge clk); #1;
    host_wr = 1'b0; host_rd = 1'b0;
  endtask

  initial begin
    logic [15:0] q, first, second;
    int w;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    // R8 reset state at the ports
    chk("R8 ready after reset", {15'd0, host_ready}, 16'd1);
    chk("R8 no write after reset", {15'd0, mem_we}, 16'd0);
    // R8 location 0 and step 0: both writes land at word 0
    op(2'd1, 1, 16'h1111, q, w);
    op(2'd1, 1, 16'h2222, q, w);
    op(2'd0, 0, 16'h0, q, w);
    chk("R8 loc and step reset to 0", q, 16'h2222);
    chk("R8 word 1 untouched", ram[1], 16'h0000);

    foreach (VEC[i]) begin
      logic [15:0] l, s, d;
      {l, s, d} = VEC[i];
      op(2'd0, 1, l, q, w);
      op(2'd2, 1, s, q, w);
      op(2'd1, 1, d, q, w);
      chk("R9 window write ready at once", 16'(w), 16'd0);
      op(2'd1, 1, ~d, q, w);
      first  = (s[7:0] == 8'h00) ? ~d : d;
      second = ~d;
      op(2'd0, 1, l, q, w);
      op(2'd0, 0, 16'h0, q, w);
      chk("R4 location read gives data", q, first);
      chk("R9 one wait after location write", 16'(w), 16'd1);
      op(2'd1, 0, 16'h0, q, w);
      chk("R3 window read at location", q, first);
      op(2'd1, 0, 16'h0, q, w);
      chk((s == 0) ? "R5 zero step" : (i >= 2 ? "R6 wrapped step" : "R2 stepped write"), q, second);
      chk("R9 one wait after window read", 16'(w), 16'd1);
    end

    // R1 offsets 2 and 3 read 0, write to 3 ignored
    op(2'd0, 1, 16'h0010, q, w);
    op(2'd2, 0, 16'h0, q, w);
    chk("R1 step offset reads 0", q, 16'h0000);
    op(2'd3, 0, 16'h0, q, w);
    chk("R1 offset 3 reads 0", q, 16'h0000);
    op(2'd3, 1, 16'h00AA, q, w);
    op(2'd0, 0, 16'h0, q, w);
    chk("R1 offset 3 write ignored", q, 16'h1234);

    // R7 stall holds a window write
    op(2'd0, 1, 16'h0030, q, w);
    op(2'd2, 1, 16'h0003, q, w);
    @(negedge clk);
    vid_stall = 1'b1;
    host_addr = 2'd1; host_wr = 1'b1; host_wdata = 16'hBEEF;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R7 ready low in stall", {15'd0, host_ready}, 16'd0);
      chk("R7 no RAM write in stall", {15'd0, mem_we}, 16'd0);
      @(negedge clk);
    end
    vid_stall = 1'b0;
    #1;
    chk("R7 ready after stall", {15'd0, host_ready}, 16'd1);
    @(posedge clk); #1;
    host_wr = 1'b0;
    op(2'd1, 1, 16'hCAFE, q, w);
    op(2'd0, 1, 16'h0030, q, w);
    op(2'd1, 0, 16'h0, q, w);
    chk("R7 held write landed once", q, 16'hBEEF);
    op(2'd1, 0, 16'h0, q, w);
    chk("R7 single advance", q, 16'hCAFE);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule